// File: doc/BRIEF.md
# DMA Address Translation Front-End

This block sits on the command path from peripheral DMA engines towards memory. Each incoming command packet carries a 32-bit virtual address on every flit. The block looks the address of the first flit up in a translation cache and forwards the whole packet with a 40-bit physical address. The cache answers in the same cycle through a simple lookup port. When the cache has no entry, the packet is held at the input and a page-table walker is asked to refill. The lookup is repeated once the walker reports completion.

An illegal access is either a page with no mapping or a write to a read-only page. On an illegal access the block swallows the rest of the packet and records the fault details. It then emits an interrupt write to a programmable 64-bit address and returns an error response to the initiator. A bypass mode forwards addresses without translation. Each forwarded packet carries a route flag that is set when its physical page lies in the interrupt-write region, so the downstream network steers it away from memory.

Top module: `dma_xlate_front`

## Requirements
- R1: With translation active, a first flit whose lookup returns hit, mapped, and either writable or a read, is forwarded. Every flit of the packet leaves with mem_addr = {lk_ppn, in_addr[11:0]}, and its data, write flag, source and last flag are unchanged.
- R2: With cfg_active low, lk_req stays low and every flit leaves with its 32-bit address zero-extended to 40 bits.
- R3: On a lookup miss (lk_hit low), walk_req rises and in_ready stays low. No flit is lost or forwarded. After walk_done the address is looked up again and, on a hit, the packet is forwarded as in R1.
- R4: A lookup that returns hit with lk_mapped low is a fault with code 1. A write (in_write high) to a page with lk_writable low is a fault with code 2. A read of such a page is not a fault.
- R5: After a fault, every remaining flit up to and including the last is accepted and none reaches the memory port. Then one interrupt write to {cfg_irq_addr_hi, cfg_irq_addr_lo} is issued, and after it one error response carrying the faulting source.
- R6: With cfg_irq_en low, a fault skips the interrupt write and goes straight to the error response.
- R7: On a fault, flt_vaddr, flt_code and flt_src capture the first-flit address, the code and the source. They hold these values until the next fault, and are zero after reset.
- R8: The translation found for the first flit applies to every flit of the packet. Later flits keep their own low 12 address bits, and all flits of a packet stay inside one 64-byte line.
- R9: mem_route is 1 exactly when the physical page address, masked with IRQ_MASK, equals IRQ_BASE (defaults: the top 8 bits equal to 0xF0).
- R10: After reset, in_ready, mem_valid, fw_valid, er_valid, walk_req and lk_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_active | input | 1 | 1 translates addresses, 0 bypasses translation |
| cfg_irq_en | input | 1 | Allows the fault interrupt write |
| cfg_irq_addr_lo | input | 32 | Fault interrupt address, low half |
| cfg_irq_addr_hi | input | 32 | Fault interrupt address, high half |
| in_valid | input | 1 | Command flit valid |
| in_ready | output | 1 | Command flit accepted |
| in_addr | input | 32 | Virtual address of the flit |
| in_write | input | 1 | 1 for write, 0 for read |
| in_data | input | 64 | Flit data |
| in_src | input | 8 | Initiator source ID |
| in_last | input | 1 | Last flit of the packet |
| lk_req | output | 1 | Lookup request to the translation cache |
| lk_vpn | output | 20 | Virtual page number for lookup and walker |
| lk_hit | input | 1 | Cache holds an entry for lk_vpn |
| lk_mapped | input | 1 | The entry is a valid mapping |
| lk_writable | input | 1 | The page accepts writes |
| lk_ppn | input | 28 | Physical page number |
| walk_req | output | 1 | Refill request to the walker |
| walk_done | input | 1 | Walker finished the refill |
| mem_valid | output | 1 | Translated flit valid |
| mem_ready | input | 1 | Downstream accepts the flit |
| mem_addr | output | 40 | Physical address |
| mem_write | output | 1 | Write flag |
| mem_data | output | 64 | Data |
| mem_src | output | 8 | Source ID |
| mem_last | output | 1 | Last flit |
| mem_route | output | 1 | 1 routes the packet as an interrupt write |
| fw_valid | output | 1 | Fault interrupt write valid |
| fw_ready | input | 1 | Fault interrupt write accepted |
| fw_addr | output | 64 | Fault interrupt write address |
| er_valid | output | 1 | Error response valid |
| er_ready | input | 1 | Error response accepted |
| er_src | output | 8 | Source that receives the error |
| flt_vaddr | output | 32 | Last faulting virtual address |
| flt_code | output | 2 | Last fault code (1 unmapped, 2 read-only) |
| flt_src | output | 8 | Last faulting source |

## Verification
The assertions take some behaviour of the block's neighbours for granted. A flit held while in_ready is low keeps its values. All flits of a packet stay inside one 64-byte line. The configuration inputs do not change while a packet is in flight. The lookup port answers in the same cycle. The stimulus meets these conditions as follows. The driver holds each flit until it is accepted. It builds multi-flit packets as consecutive 8-byte steps from a line-aligned base. It changes the active and interrupt-enable settings only between packets, once every expected output has drained. The cache model is a combinational function of lk_vpn.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [2:0] {
      XS_IDLE,
      XS_PASS,
      XS_WALK,
      XS_DRAIN,
      XS_FWRITE,
      XS_ERESP
   } xl_state_e;

   typedef enum logic [1:0] {
      XV_MISS,
      XV_OK,
      XV_UNMAPPED,
      XV_READONLY
   } xl_verdict_e;

   localparam logic [1:0] FCODE_NONE     = 2'd0;
   localparam logic [1:0] FCODE_UNMAPPED = 2'd1;
   localparam logic [1:0] FCODE_READONLY = 2'd2;

   function automatic xl_verdict_e classify(input logic hit, input logic mapped,
                                            input logic writable, input logic is_wr);
      xl_verdict_e v;
      if (!hit)                  v = XV_MISS;
      else if (!mapped)          v = XV_UNMAPPED;
      else if (is_wr && !writable) v = XV_READONLY;
      else                       v = XV_OK;
      return v;
   endfunction

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
   import xlate_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_active,
   input  logic        cfg_irq_en,
   input  logic        in_valid,
   input  logic        in_last,
   input  xl_verdict_e verdict,
   input  logic        walk_done,
   input  logic        mem_ready,
   input  logic        fw_ready,
   input  logic        er_ready,
   output logic        in_ready,
   output logic        fwd_valid,
   output logic        lk_req,
   output logic        walk_req,
   output logic        fw_valid,
   output logic        er_valid,
   output logic        take_page,
   output logic        fault_stb,
   output logic [1:0]  fault_code
);

   xl_state_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= XS_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d       = st_q;
      in_ready   = 1'b0;
      fwd_valid  = 1'b0;
      lk_req     = 1'b0;
      walk_req   = 1'b0;
      fw_valid   = 1'b0;
      er_valid   = 1'b0;
      take_page  = 1'b0;
      fault_stb  = 1'b0;
      fault_code = FCODE_NONE;
      case (st_q)
         XS_IDLE: begin
            if (in_valid) begin
               if (!cfg_active) begin
                  take_page = 1'b1;
                  st_d      = XS_PASS;
               end else begin
                  lk_req = 1'b1;
                  case (verdict)
                     XV_MISS: st_d = XS_WALK;
                     XV_OK: begin
                        take_page = 1'b1;
                        st_d      = XS_PASS;
                     end
                     XV_UNMAPPED: begin
                        fault_stb  = 1'b1;
                        fault_code = FCODE_UNMAPPED;
                        st_d       = XS_DRAIN;
                     end
                     default: begin
                        fault_stb  = 1'b1;
                        fault_code = FCODE_READONLY;
                        st_d       = XS_DRAIN;
                     end
                  endcase
               end
            end
         end
         XS_PASS: begin
            fwd_valid = in_valid;
            in_ready  = mem_ready;
            if (in_valid && mem_ready && in_last) st_d = XS_IDLE;
         end
         XS_WALK: begin
            walk_req = 1'b1;
            if (walk_done) st_d = XS_IDLE;
         end
         XS_DRAIN: begin
            in_ready = 1'b1;
            if (in_valid && in_last) st_d = cfg_irq_en ? XS_FWRITE : XS_ERESP;
         end
         XS_FWRITE: begin
            fw_valid = 1'b1;
            if (fw_ready) st_d = XS_ERESP;
         end
         XS_ERESP: begin
            er_valid = 1'b1;
            if (er_ready) st_d = XS_IDLE;
         end
         default: st_d = XS_IDLE;
      endcase
   end

   AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_valid, walk_req, fw_valid, er_valid, lk_req})) else $error("outputs overlap"); // R5
   AST_WALK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> !in_ready) else $error("flit taken during walk"); // R3
   AST_WALK_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req && !walk_done |=> walk_req) else $error("walk dropped"); // R3
   AST_FW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      fw_valid |-> cfg_irq_en) else $error("fault write while disabled"); // R6
   AST_ERR_AFTER_FW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(er_valid) && cfg_irq_en |-> $past(fw_valid)) else $error("error before fault write"); // R5

endmodule

// File: rtl/xlate_page_reg.sv
module xlate_page_reg #(
   parameter int VPN_W    = 20,
   parameter int PPN_W    = 28,
   parameter int PG_OFF   = 12,
   parameter bit ROUTE_EN = 1'b1,
   parameter logic [PPN_W+PG_OFF-1:0] IRQ_BASE = '0,
   parameter logic [PPN_W+PG_OFF-1:0] IRQ_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_page,
   input  logic             use_xlate,
   input  logic [VPN_W-1:0] vpn,
   input  logic [PPN_W-1:0] ppn,
   output logic [PPN_W-1:0] page_q,
   output logic             route_q
);

   localparam int PA_W  = PPN_W + PG_OFF;
   localparam int EXT_W = PPN_W - VPN_W;

   logic [PPN_W-1:0] page_d;
   logic [PA_W-1:0]  page_addr;

   generate
      if (EXT_W > 0) begin : g_zext
         assign page_d = use_xlate ? ppn : {{EXT_W{1'b0}}, vpn};
      end else begin : g_same
         assign page_d = use_xlate ? ppn : vpn;
      end
   endgenerate

   assign page_addr = {page_d, {PG_OFF{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         page_q <= '0;
      else if (take_page) page_q <= page_d;
   end

   generate
      if (ROUTE_EN) begin : g_route
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         route_q <= 1'b0;
            else if (take_page) route_q <= ((page_addr & IRQ_MASK) == IRQ_BASE);
         end
      end else begin : g_noroute
         logic unused_addr;
         assign unused_addr = ^page_addr;
         assign route_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/xlate_fault_log.sv
module xlate_fault_log #(
   parameter int VA_W  = 32,
   parameter int SRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault_stb,
   input  logic [1:0]       fault_code,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [SRC_W-1:0] src,
   output logic [VA_W-1:0]  flt_vaddr,
   output logic [1:0]       flt_code,
   output logic [SRC_W-1:0] flt_src
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_vaddr <= '0;
         flt_code  <= '0;
         flt_src   <= '0;
      end else if (fault_stb) begin
         flt_vaddr <= vaddr;
         flt_code  <= fault_code;
         flt_src   <= src;
      end
   end

   AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      fault_stb |=> flt_code != 2'd0) else $error("fault code not latched"); // R7
   AST_LOG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_stb |=> $stable(flt_vaddr) && $stable(flt_src)) else $error("log changed"); // R7

endmodule

// File: rtl/dma_xlate_front.sv
module dma_xlate_front
   import xlate_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 40,
   parameter int PG_OFF     = 12,
   parameter int DATA_W     = 64,
   parameter int SRC_W      = 8,
   parameter int LINE_BYTES = 64,
   parameter bit ROUTE_EN   = 1'b1,
   parameter logic [PA_W-1:0] IRQ_BASE = 40'hF0_0000_0000,
   parameter logic [PA_W-1:0] IRQ_MASK = 40'hFF_0000_0000,
   localparam int VPN_W = VA_W - PG_OFF,
   localparam int PPN_W = PA_W - PG_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_active,
   input  logic              cfg_irq_en,
   input  logic [31:0]       cfg_irq_addr_lo,
   input  logic [31:0]       cfg_irq_addr_hi,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [VA_W-1:0]   in_addr,
   input  logic              in_write,
   input  logic [DATA_W-1:0] in_data,
   input  logic [SRC_W-1:0]  in_src,
   input  logic              in_last,
   output logic              lk_req,
   output logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_hit,
   input  logic              lk_mapped,
   input  logic              lk_writable,
   input  logic [PPN_W-1:0]  lk_ppn,
   output logic              walk_req,
   input  logic              walk_done,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [PA_W-1:0]   mem_addr,
   output logic              mem_write,
   output logic [DATA_W-1:0] mem_data,
   output logic [SRC_W-1:0]  mem_src,
   output logic              mem_last,
   output logic              mem_route,
   output logic              fw_valid,
   input  logic              fw_ready,
   output logic [63:0]       fw_addr,
   output logic              er_valid,
   input  logic              er_ready,
   output logic [SRC_W-1:0]  er_src,
   output logic [VA_W-1:0]   flt_vaddr,
   output logic [1:0]        flt_code,
   output logic [SRC_W-1:0]  flt_src
);

   localparam int LINE_LOG = $clog2(LINE_BYTES);

   generate
      if (PA_W < VA_W)         $error("physical width below virtual width");
      if (PG_OFF <= LINE_LOG)  $error("page must exceed one line");
      if (PA_W > 64)           $error("physical width above 64");
      if ((1 << LINE_LOG) != LINE_BYTES) $error("line size not a power of two");
   endgenerate

   xl_verdict_e      verdict;
   logic             take_page;
   logic             fault_stb;
   logic [1:0]       fault_code;
   logic [PPN_W-1:0] page_q;
   logic             route_q;

   assign lk_vpn  = in_addr[VA_W-1:PG_OFF];
   assign verdict = classify(lk_hit, lk_mapped, lk_writable, in_write);

   xlate_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_active (cfg_active),
      .cfg_irq_en (cfg_irq_en),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .verdict    (verdict),
      .walk_done  (walk_done),
      .mem_ready  (mem_ready),
      .fw_ready   (fw_ready),
      .er_ready   (er_ready),
      .in_ready   (in_ready),
      .fwd_valid  (mem_valid),
      .lk_req     (lk_req),
      .walk_req   (walk_req),
      .fw_valid   (fw_valid),
      .er_valid   (er_valid),
      .take_page  (take_page),
      .fault_stb  (fault_stb),
      .fault_code (fault_code)
   );

   xlate_page_reg #(
      .VPN_W    (VPN_W),
      .PPN_W    (PPN_W),
      .PG_OFF   (PG_OFF),
      .ROUTE_EN (ROUTE_EN),
      .IRQ_BASE (IRQ_BASE),
      .IRQ_MASK (IRQ_MASK)
   ) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_page (take_page),
      .use_xlate (cfg_active),
      .vpn       (lk_vpn),
      .ppn       (lk_ppn),
      .page_q    (page_q),
      .route_q   (route_q)
   );

   xlate_fault_log #(
      .VA_W  (VA_W),
      .SRC_W (SRC_W)
   ) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_stb  (fault_stb),
      .fault_code (fault_code),
      .vaddr      (in_addr),
      .src        (in_src),
      .flt_vaddr  (flt_vaddr),
      .flt_code   (flt_code),
      .flt_src    (flt_src)
   );

   assign mem_addr  = {page_q, in_addr[PG_OFF-1:0]};
   assign mem_write = in_write;
   assign mem_data  = in_data;
   assign mem_src   = in_src;
   assign mem_last  = in_last;
   assign mem_route = route_q;
   assign fw_addr   = {cfg_irq_addr_hi, cfg_irq_addr_lo};
   assign er_src    = flt_src;

   AST_BYPASS_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_active |-> !lk_req) else $error("lookup in bypass"); // R2
   AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && !mem_last |=>
         !mem_valid || mem_addr[PA_W-1:PG_OFF] == $past(mem_addr[PA_W-1:PG_OFF]))
      else $error("page changed inside packet"); // R8
   AST_LINE_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_last |=>
         !in_valid || in_addr[VA_W-1:LINE_LOG] == $past(in_addr[VA_W-1:LINE_LOG]))
      else $error("packet crosses a line"); // R8
   AST_NO_FWD_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault_stb |=> !mem_valid) else $error("faulty flit forwarded"); // R5

endmodule

// File: tb/sim_dma_xlate_front.sv
`timescale 1ns/1ps
module sim_dma_xlate_front;

   typedef struct packed {
      logic [39:0] a;
      logic [63:0] d;
      logic        w;
      logic [7:0]  s;
      logic        l;
      logic        r;
   } beat_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_active = 1'b1, cfg_irq_en = 1'b1;
   logic [31:0] cfg_irq_addr_lo = 32'hCAFE_0010, cfg_irq_addr_hi = 32'h0000_00AB;
   logic in_valid = 0, in_write = 0, in_last = 0;
   logic [31:0] in_addr = 0;
   logic [63:0] in_data = 0;
   logic [7:0]  in_src = 0;
   logic in_ready, lk_req, walk_req, mem_valid, mem_write, mem_last, mem_route;
   logic fw_valid, er_valid;
   logic [19:0] lk_vpn;
   logic lk_hit, lk_mapped, lk_writable;
   logic [27:0] lk_ppn;
   logic walk_done = 0, filled = 0;
   logic mem_ready = 1, fw_ready = 1, er_ready = 1, stall_mode = 0;
   logic [39:0] mem_addr;
   logic [63:0] mem_data, fw_addr;
   logic [7:0]  mem_src, er_src, flt_src;
   logic [31:0] flt_vaddr;
   logic [1:0]  flt_code;

   int n_chk = 0, n_fail = 0, lk_cnt = 0, walk_cnt = 0, fw_seen = 0, fw_pushed = 0;
   beat_t mq[$];
   string mreq[$];
   logic [63:0] fq[$];
   logic [7:0]  eq_src[$];
   int          eq_fwc[$];

   always #2 clk = ~clk;

   dma_xlate_front u0 (.*);

   // translation cache model
   always_comb begin
      lk_hit = 1'b1; lk_mapped = 1'b1; lk_writable = 1'b1; lk_ppn = '0;
      case (lk_vpn)
         20'h00010: lk_ppn = 28'h0ABCDE1;
         20'h00020: begin lk_ppn = 28'h0000777; lk_writable = 1'b0; end
         20'h00040: begin lk_hit = filled; lk_ppn = 28'h0000999; end
         20'h00050: lk_ppn = 28'hF000012;
         default:   lk_mapped = 1'b0;
      endcase
   end

   // walker model: completes after three request cycles
   int wcnt = 0;
   always @(posedge clk) begin
      walk_done <= 1'b0;
      if (walk_req && !walk_done && !filled) begin
         wcnt <= wcnt + 1;
         if (wcnt == 2) begin walk_done <= 1'b1; filled <= 1'b1; end
      end
      mem_ready <= stall_mode ? ~mem_ready : 1'b1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor
   always @(negedge clk) if (rst_n) begin
      if (lk_req) lk_cnt++;
      if (walk_req) walk_cnt++;
      if (mem_valid && mem_ready) begin
         if (mq.size() == 0) chk(0, "R5 unexpected beat", {24'h0, mem_addr}, 64'h0);
         else begin
            beat_t e; string rq;
            e = mq.pop_front(); rq = mreq.pop_front();
            chk(mem_addr == e.a, rq, {24'h0, mem_addr}, {24'h0, e.a});
            chk({mem_data, mem_write, mem_src, mem_last, mem_route} == {e.d, e.w, e.s, e.l, e.r},
                rq, {mem_route, mem_last, mem_write, 13'h0, mem_src, mem_data[39:0]},
                {e.r, e.l, e.w, 13'h0, e.s, e.d[39:0]});
         end
      end
      if (fw_valid && fw_ready) begin
         fw_seen++;
         if (fq.size() == 0) chk(0, "R6 unexpected fault write", fw_addr, 64'h0);
         else begin
            logic [63:0] ea;
            ea = fq.pop_front();
            chk(fw_addr == ea, "R5 fault write address", fw_addr, ea);
         end
      end
      if (er_valid && er_ready) begin
         if (eq_src.size() == 0) chk(0, "R5 unexpected error response", {56'h0, er_src}, 64'h0);
         else begin
            logic [7:0] es; int ef;
            es = eq_src.pop_front(); ef = eq_fwc.pop_front();
            chk(er_src == es, "R5 error source", {56'h0, er_src}, {56'h0, es});
            chk(fw_seen == ef, "R5 R6 order of fault write", 64'(fw_seen), 64'(ef));
         end
      end
   end

   task automatic send_pkt(input logic [31:0] va, input int n, input bit wr, input logic [7:0] src,
                           input bit fwd, input logic [39:0] pa, input bit route, input string req);
      for (int i = 0; i < n; i++) begin
         if (fwd) begin
            mq.push_back('{a: pa + 40'(8 * i), d: {src, 24'(i), va}, w: wr, s: src,
                           l: (i == n - 1), r: route});
            mreq.push_back(req);
         end
      end
      for (int i = 0; i < n; i++) begin
         in_addr  = va + 32'(8 * i);
         in_data  = {src, 24'(i), va};
         in_write = wr;
         in_src   = src;
         in_last  = (i == n - 1);
         in_valid = 1'b1;
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      in_valid = 1'b0;
      for (int k = 0; k < 300 && (mq.size() != 0 || fq.size() != 0 || eq_src.size() != 0); k++)
         @(negedge clk);
      repeat (3) @(negedge clk);
      chk(mq.size() == 0 && fq.size() == 0 && eq_src.size() == 0, {req, " drained"},
          64'(mq.size() + fq.size() + eq_src.size()), 64'h0);
      @(posedge clk); #1;
   endtask

   task automatic expect_fault(input logic [7:0] src);
      if (cfg_irq_en) begin
         fq.push_back({cfg_irq_addr_hi, cfg_irq_addr_lo});
         fw_pushed++;
      end
      eq_src.push_back(src);
      eq_fwc.push_back(fw_pushed);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk({in_ready, mem_valid, fw_valid, er_valid, walk_req, lk_req} == 6'b0, "R10 idle outputs",
          {58'h0, in_ready, mem_valid, fw_valid, er_valid, walk_req, lk_req}, 64'h0);
      chk({flt_vaddr, flt_code, flt_src} == '0, "R7 log reset", {22'h0, flt_vaddr, flt_code, flt_src}, 64'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 R8 four-flit write with backpressure, offsets change per flit
      stall_mode = 1'b1;
      send_pkt(32'h0001_0040, 4, 1'b1, 8'h11, 1'b1, 40'h0A_BCDE_1040, 1'b0, "R1 R8 hit write");
      stall_mode = 1'b0;
      // R1 single-flit read
      send_pkt(32'h0001_0FC0, 1, 1'b0, 8'h12, 1'b1, 40'h0A_BCDE_1FC0, 1'b0, "R1 hit read");
      // R4 read of read-only page is allowed
      send_pkt(32'h0002_0100, 2, 1'b0, 8'h13, 1'b1, 40'h00_0077_7100, 1'b0, "R4 read-only read");
      chk(flt_code == 2'd0, "R7 no fault logged", {62'h0, flt_code}, 64'h0);

      // R2 bypass: zero-extension, no lookup
      cfg_active = 1'b0; lk_cnt = 0;
      send_pkt(32'hFFFF_F008, 2, 1'b1, 8'h21, 1'b1, 40'h00_FFFF_F008, 1'b0, "R2 bypass");
      chk(lk_cnt == 0, "R2 no lookup in bypass", 64'(lk_cnt), 64'h0);
      cfg_active = 1'b1;

      // R3 miss, walk, re-lookup
      walk_cnt = 0; lk_cnt = 0;
      send_pkt(32'h0004_0080, 3, 1'b1, 8'h31, 1'b1, 40'h00_0099_9080, 1'b0, "R3 miss then hit");
      chk(walk_cnt >= 3, "R3 walk requested", 64'(walk_cnt), 64'h3);
      chk(lk_cnt == 2, "R3 looked up again", 64'(lk_cnt), 64'h2);

      // R4 R5 R7 unmapped page write, three flits drained
      expect_fault(8'h5A);
      send_pkt(32'h0003_0200, 3, 1'b1, 8'h5A, 1'b0, 40'h0, 1'b0, "R5 unmapped drain");
      chk(flt_code == 2'd1, "R4 R7 unmapped code", {62'h0, flt_code}, 64'h1);
      chk(flt_vaddr == 32'h0003_0200 && flt_src == 8'h5A, "R7 fault vaddr and src",
          {24'h0, flt_src, flt_vaddr}, {24'h0, 8'h5A, 32'h0003_0200});

      // R4 write to read-only page
      cfg_irq_addr_lo = 32'h1234_5678; cfg_irq_addr_hi = 32'h0000_0F0F;
      expect_fault(8'h33);
      send_pkt(32'h0002_0008, 1, 1'b1, 8'h33, 1'b0, 40'h0, 1'b0, "R4 read-only write");
      chk(flt_code == 2'd2, "R4 read-only code", {62'h0, flt_code}, 64'h2);

      // R7 log holds after a good packet
      send_pkt(32'h0001_0000, 1, 1'b0, 8'h44, 1'b1, 40'h0A_BCDE_1000, 1'b0, "R1 after fault");
      chk(flt_code == 2'd2 && flt_src == 8'h33, "R7 log held", {54'h0, flt_code, flt_src},
          {54'h0, 2'd2, 8'h33});

      // R6 fault with interrupt write disabled
      cfg_irq_en = 1'b0;
      expect_fault(8'h66);
      send_pkt(32'h0007_0000, 2, 1'b0, 8'h66, 1'b0, 40'h0, 1'b0, "R6 no fault write");
      chk(fw_seen == fw_pushed, "R6 fault writes seen", 64'(fw_seen), 64'(fw_pushed));
      cfg_irq_en = 1'b1;

      // R9 route into interrupt-write region
      send_pkt(32'h0005_0010, 2, 1'b1, 8'h77, 1'b1, 40'hF0_0001_2010, 1'b1, "R9 route to irq region");

      finish_run();
   end

endmodule